// File: doc/BRIEF.md
# Management-side three-register message responder

This block sits on the controller side of a byte-wide, three-register host mailbox. A host reaches it through a small register bus: a data register, a control/status register and a flags register. The host places a data byte, writes a control code, then sets the busy flag. After a programmable processing delay, the responder acts on the code. It pushes request bytes into an external request FIFO, or pops response bytes from an external response FIFO into the data register. It then writes a status code that echoes the accepted operation and clears busy.

The host drives a request as write-start, any number of write-next, then write-end. It collects the answer as read-start, read-next until the final byte, then read-end. A get-status code returns the responder to the ready phase from any point. An unknown code, or an operation that does not fit the current phase, gives a reject status so the host can begin recovery. Both FIFOs are show-ahead and sit outside the block. The processing delay is an input, so firmware or a test can stretch every step.

Top module: `mc_reg_responder`

## Requirements
- R1: After reset the status register (offset 1) reads 0xC0, the data register (offset 0) reads 0x00 and busy is clear.
- R2: The flags register (offset 2) has these bits. Bit 7 means the response FIFO is not empty. Bit 6 means the request FIFO is not full. Bit 2 means a response is waiting while the responder is in the ready phase. Bit 0 is busy. All other bits read 0, so flags never reads 0xFF. Offset 3 reads 0x00.
- R3: A host write to offset 2 with bit 0 set, while busy is clear, sets busy. Busy then reads 1 for exactly proc_delay+1 clock cycles, and the responder alone clears it. A host write of 0 to bit 0 does not clear busy.
- R4: Host writes to the data and control registers while busy is set are ignored.
- R5: Codes 0x41 (write-start, only from ready), 0x42 (write-next) and 0x43 (write-end) each push the data register into the request FIFO. Write-next and write-end are accepted only after a write-start or write-next. The end marker is set only for 0x43. The status becomes 0xC1, 0xC2 or 0xC3.
- R6: After an accepted write-end the data register reads 0x00.
- R7: Code 0x44 (read-start), accepted only right after write-end, pops the first response byte into the data register and gives status 0xC4.
- R8: Code 0x45 (read-next) pops the next byte into the data register. The status is 0xC5 when that byte is not the last of the message, and 0xC6 when it is.
- R9: Code 0x46 (read-end), accepted after the last byte has been delivered, gives status 0xC0 and data 0x00.
- R10: Code 0x40 (get-status) gives status 0xC0 and returns the responder to the ready phase from any phase.
- R11: An unknown code, a code out of order, a push while the request FIFO is full, or a pop while the response FIFO is empty gives status 0xCF. In that case no FIFO transfer happens and the responder returns to the ready phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe for one cycle |
| hst_wr | input | 1 | Host access is a write |
| hst_addr | input | 2 | Register offset: 0 data, 1 control/status, 2 flags |
| hst_wdata | input | 8 | Host write byte |
| hst_rdata | output | 8 | Register read byte (combinational from hst_addr) |
| proc_delay | input | DLY_W | Cycles to wait before acting on a step |
| req_wr | output | 1 | Push strobe into the request FIFO |
| req_byte | output | 8 | Byte pushed into the request FIFO |
| req_eom | output | 1 | End-of-message marker for the pushed byte |
| req_full | input | 1 | Request FIFO has no room |
| rsp_rd | output | 1 | Pop strobe for the response FIFO |
| rsp_byte | input | 8 | Head byte of the response FIFO |
| rsp_last | input | 1 | Head byte is the last byte of its message |
| rsp_empty | input | 1 | Response FIFO is empty |

## Verification
The hardest conditions to reach are the window where busy is still set and the host keeps writing, and the rejections that depend on the state of a FIFO rather than on the code. The bench makes the processing delay long so that several host writes land inside one busy window, then checks that the step completes with the original code and data. It holds the request-full input high around a write-start, and drains the response model before a read-start, so that the reject path is taken on FIFO state alone. The bench also counts the busy cycles directly at the flags register.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;
   localparam int BYTE_W = 8;

   localparam logic [1:0] OFS_DATA  = 2'd0;
   localparam logic [1:0] OFS_CTRL  = 2'd1;
   localparam logic [1:0] OFS_FLAGS = 2'd2;

   localparam int FB_RX   = 7;
   localparam int FB_TX   = 6;
   localparam int FB_MSG  = 2;
   localparam int FB_BUSY = 0;

   // upper nibble of a primary-channel control code
   localparam logic [3:0] CH_MAIN = 4'h4;

   localparam logic [3:0] OP_STAT   = 4'h0;
   localparam logic [3:0] OP_WSTART = 4'h1;
   localparam logic [3:0] OP_WNEXT  = 4'h2;
   localparam logic [3:0] OP_WEND   = 4'h3;
   localparam logic [3:0] OP_RSTART = 4'h4;
   localparam logic [3:0] OP_RNEXT  = 4'h5;
   localparam logic [3:0] OP_REND   = 4'h6;
   localparam logic [3:0] OP_REJECT = 4'hF;

   typedef enum logic [2:0] {
      PH_READY, PH_WRITING, PH_WRDONE, PH_READING, PH_RDLAST
   } phase_t;

   typedef struct packed {
      phase_t     nxt;
      logic [3:0] op;
      logic       push;
      logic       eom;
      logic       pop;
      logic       clr_data;
   } step_t;

   function automatic logic [BYTE_W-1:0] status_of(input logic [3:0] op);
      return {4'hC, op};
   endfunction
endpackage

// File: rtl/mcr_step_decode.sv
`timescale 1ns/1ps
module mcr_step_decode
   import mcr_pkg::*;
(
   input  phase_t            phase,
   input  logic [BYTE_W-1:0] code,
   input  logic              req_full,
   input  logic              rsp_empty,
   input  logic              rsp_last,
   output step_t             step
);
   always_comb begin
      step = '{nxt: PH_READY, op: OP_REJECT, push: 1'b0, eom: 1'b0,
               pop: 1'b0, clr_data: 1'b0};
      if (code[7:4] == CH_MAIN) begin
         unique case (code[3:0])
            OP_STAT: step.op = OP_STAT;
            OP_WSTART:
               if (phase == PH_READY && !req_full) begin
                  step.op = OP_WSTART; step.push = 1'b1; step.nxt = PH_WRITING;
               end
            OP_WNEXT:
               if (phase == PH_WRITING && !req_full) begin
                  step.op = OP_WNEXT; step.push = 1'b1; step.nxt = PH_WRITING;
               end
            OP_WEND:
               if (phase == PH_WRITING && !req_full) begin
                  step.op = OP_WEND; step.push = 1'b1; step.eom = 1'b1;
                  step.clr_data = 1'b1; step.nxt = PH_WRDONE;
               end
            OP_RSTART:
               if (phase == PH_WRDONE && !rsp_empty) begin
                  step.op  = OP_RSTART; step.pop = 1'b1;
                  step.nxt = rsp_last ? PH_RDLAST : PH_READING;
               end
            OP_RNEXT:
               if (phase == PH_READING && !rsp_empty) begin
                  step.pop = 1'b1;
                  step.op  = rsp_last ? OP_REND : OP_RNEXT;
                  step.nxt = rsp_last ? PH_RDLAST : PH_READING;
               end
            OP_REND:
               if (phase == PH_RDLAST) begin
                  step.op = OP_STAT; step.clr_data = 1'b1;
               end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/mcr_busy_timer.sv
`timescale 1ns/1ps
module mcr_busy_timer #(
   parameter int DLY_W     = 8,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [DLY_W-1:0] delay,
   output logic             busy,
   output logic             fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     busy <= 1'b0;
      else if (start) busy <= 1'b1;
      else if (fire)  busy <= 1'b0;
   end

   generate
      if (USE_DELAY) begin : g_count
         logic [DLY_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (start) cnt <= delay;
            else if (busy && cnt != '0) cnt <= cnt - 1'b1;
         end
         assign fire = busy && (cnt == '0);
      end else begin : g_direct
         assign fire = busy;
      end
   endgenerate
endmodule

// File: rtl/mc_reg_responder.sv
`timescale 1ns/1ps
module mc_reg_responder
   import mcr_pkg::*;
#(
   parameter int DLY_W     = 8,
   parameter bit USE_DELAY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hst_sel,
   input  logic              hst_wr,
   input  logic [1:0]        hst_addr,
   input  logic [7:0]        hst_wdata,
   output logic [7:0]        hst_rdata,
   input  logic [DLY_W-1:0]  proc_delay,
   output logic              req_wr,
   output logic [7:0]        req_byte,
   output logic              req_eom,
   input  logic              req_full,
   output logic              rsp_rd,
   input  logic [7:0]        rsp_byte,
   input  logic              rsp_last,
   input  logic              rsp_empty
);
   generate
      if (DLY_W < 1 || DLY_W > 24) begin : g_bad_dly
         $error("mc_reg_responder: DLY_W must lie in 1..24");
      end
      if (BYTE_W != 8) begin : g_bad_byte
         $error("mc_reg_responder: register width must be 8");
      end
   endgenerate

   logic [BYTE_W-1:0] data_q, ctrl_q, status_q, flags_v;
   phase_t            phase_q;
   step_t             step;
   logic              busy, fire, wr_ok, start;

   assign wr_ok = hst_sel && hst_wr && !busy;
   assign start = wr_ok && hst_addr == OFS_FLAGS && hst_wdata[FB_BUSY];

   mcr_busy_timer #(.DLY_W(DLY_W), .USE_DELAY(USE_DELAY)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .delay(proc_delay),
      .busy(busy), .fire(fire)
   );

   mcr_step_decode u_dec (
      .phase(phase_q), .code(ctrl_q), .req_full(req_full),
      .rsp_empty(rsp_empty), .rsp_last(rsp_last), .step(step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         ctrl_q   <= '0;
         status_q <= status_of(OP_STAT);
         phase_q  <= PH_READY;
      end else begin
         if (fire) begin
            status_q <= status_of(step.op);
            phase_q  <= step.nxt;
            if (step.pop)           data_q <= rsp_byte;
            else if (step.clr_data) data_q <= '0;
         end else if (wr_ok && hst_addr == OFS_DATA) begin
            data_q <= hst_wdata;
         end
         if (wr_ok && hst_addr == OFS_CTRL) ctrl_q <= hst_wdata;
      end
   end

   always_comb begin
      flags_v          = '0;
      flags_v[FB_RX]   = !rsp_empty;
      flags_v[FB_TX]   = !req_full;
      flags_v[FB_MSG]  = !rsp_empty && phase_q == PH_READY;
      flags_v[FB_BUSY] = busy;
   end

   always_comb begin
      unique case (hst_addr)
         OFS_DATA:  hst_rdata = data_q;
         OFS_CTRL:  hst_rdata = status_q;
         OFS_FLAGS: hst_rdata = flags_v;
         default:   hst_rdata = '0;
      endcase
   end

   assign req_wr   = fire && step.push;
   assign req_byte = data_q;
   assign req_eom  = step.eom;
   assign rsp_rd   = fire && step.pop;
endmodule

// File: rtl/mcr_responder_chk.sv
`timescale 1ns/1ps
module mcr_responder_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] hst_addr,
   input logic [7:0] hst_rdata,
   input logic       busy,
   input logic       fire,
   input logic [7:0] data,
   input logic [7:0] ctrl,
   input logic [7:0] status,
   input logic       req_wr,
   input logic       req_eom,
   input logic       req_full,
   input logic       rsp_rd,
   input logic       rsp_last,
   input logic       rsp_empty
);
   a_r2_flags_not_ff: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_addr == 2'd2) |-> (hst_rdata != 8'hFF));

   a_r3_step_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr || rsp_rd) |=> !busy);

   a_r3_transfer_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr || rsp_rd) |-> busy);

   a_r4_regs_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fire) |=> (data == $past(data) && ctrl == $past(ctrl)));

   a_r5_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      req_wr |-> !req_full);

   a_r6_wend_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && req_eom) |=> (data == 8'h00 && status == 8'hC3));

   a_r8_last_pop_status: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_rd && rsp_last) |=> (status == 8'hC4 || status == 8'hC6));

   a_r11_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_rd |-> !rsp_empty);

   a_r11_single_transfer: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_wr && rsp_rd));
endmodule

bind mc_reg_responder mcr_responder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_rdata(hst_rdata),
   .busy(busy), .fire(fire), .data(data_q), .ctrl(ctrl_q), .status(status_q),
   .req_wr(req_wr), .req_eom(req_eom), .req_full(req_full),
   .rsp_rd(rsp_rd), .rsp_last(rsp_last), .rsp_empty(rsp_empty)
);

// File: tb/test_mc_reg_responder.sv
`timescale 1ns/1ps
module test_mc_reg_responder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       hst_sel = 1'b0, hst_wr = 1'b0;
   logic [1:0] hst_addr = 2'd0;
   logic [7:0] hst_wdata = 8'h00;
   logic [7:0] hst_rdata;
   logic [7:0] proc_delay = 8'd2;
   logic       req_wr, req_eom, rsp_rd;
   logic [7:0] req_byte, rsp_byte;
   logic       req_full = 1'b0;
   logic       rsp_last, rsp_empty;

   always #2.5 clk = ~clk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   // response FIFO model (show-ahead)
   logic [7:0] rmem [0:15];
   logic       rlm  [0:15];
   logic [4:0] rwp = '0;
   logic [4:0] rrp = '0;
   assign rsp_empty = (rwp == rrp);
   assign rsp_byte  = rmem[rrp[3:0]];
   assign rsp_last  = rlm[rrp[3:0]];
   always @(posedge clk) if (rsp_rd) rrp <= rrp + 5'd1;

   // request FIFO capture
   logic [7:0] cap_b [0:15];
   logic       cap_e [0:15];
   int         ncap = 0;
   always @(posedge clk) if (req_wr) begin
      cap_b[ncap[3:0]] <= req_byte;
      cap_e[ncap[3:0]] <= req_eom;
      ncap <= ncap + 1;
   end

   mc_reg_responder i_mc_reg_responder (
      .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
      .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .proc_delay(proc_delay), .req_wr(req_wr), .req_byte(req_byte),
      .req_eom(req_eom), .req_full(req_full), .rsp_rd(rsp_rd),
      .rsp_byte(rsp_byte), .rsp_last(rsp_last), .rsp_empty(rsp_empty)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                      input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   task automatic hw(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
      @(negedge clk);
      hst_sel = 1'b0; hst_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [7:0] exp,
                     input string req, input string what);
      @(negedge clk);
      hst_addr = a;
      #1;
      chk(hst_rdata, exp, req, what);
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         hst_addr = 2'd2;
         #1;
         if (!hst_rdata[0]) break;
      end
   endtask

   task automatic step(input logic [7:0] code, input logic [7:0] exp, input string req);
      hw(2'd1, code);
      hw(2'd2, 8'h01);
      wait_idle();
      rd(2'd1, exp, req, "status after step");
   endtask

   task automatic push_rsp(input logic [7:0] b, input logic last);
      rmem[rwp[3:0]] = b;
      rlm[rwp[3:0]]  = last;
      rwp = rwp + 5'd1;
   endtask

   localparam logic [1:0] KW = 2'd0, KR = 2'd1, KB = 2'd2;
   localparam int NV = 38;
   // {kind, offset, byte, requirement number}
   localparam logic [15:0] TBL [0:NV-1] = '{
      {KW, 2'd0, 8'h11, 4'd5}, {KW, 2'd1, 8'h41, 4'd5}, {KW, 2'd2, 8'h01, 4'd5},
      {KB, 2'd0, 8'h00, 4'd5}, {KR, 2'd1, 8'hC1, 4'd5},                  // R5 start
      {KW, 2'd0, 8'h22, 4'd5}, {KW, 2'd1, 8'h42, 4'd5}, {KW, 2'd2, 8'h01, 4'd5},
      {KB, 2'd0, 8'h00, 4'd5}, {KR, 2'd1, 8'hC2, 4'd5},                  // R5 next
      {KW, 2'd0, 8'h33, 4'd5}, {KW, 2'd1, 8'h43, 4'd5}, {KW, 2'd2, 8'h01, 4'd5},
      {KB, 2'd0, 8'h00, 4'd5}, {KR, 2'd1, 8'hC3, 4'd5},                  // R5 end
      {KR, 2'd0, 8'h00, 4'd6}, {KR, 2'd2, 8'hC0, 4'd2},                  // R6, R2
      {KW, 2'd1, 8'h44, 4'd7}, {KW, 2'd2, 8'h01, 4'd7}, {KB, 2'd0, 8'h00, 4'd7},
      {KR, 2'd1, 8'hC4, 4'd7}, {KR, 2'd0, 8'hA1, 4'd7},                  // R7
      {KW, 2'd1, 8'h45, 4'd8}, {KW, 2'd2, 8'h01, 4'd8}, {KB, 2'd0, 8'h00, 4'd8},
      {KR, 2'd1, 8'hC5, 4'd8}, {KR, 2'd0, 8'hA2, 4'd8},                  // R8 more
      {KW, 2'd1, 8'h45, 4'd8}, {KW, 2'd2, 8'h01, 4'd8}, {KB, 2'd0, 8'h00, 4'd8},
      {KR, 2'd1, 8'hC6, 4'd8}, {KR, 2'd0, 8'hA3, 4'd8},                  // R8 last
      {KW, 2'd1, 8'h46, 4'd9}, {KW, 2'd2, 8'h01, 4'd9}, {KB, 2'd0, 8'h00, 4'd9},
      {KR, 2'd1, 8'hC0, 4'd9}, {KR, 2'd0, 8'h00, 4'd9}, {KR, 2'd2, 8'h40, 4'd2} // R9, R2
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog: actual hung expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(2'd1, 8'hC0, "R1", "status after reset");
      rd(2'd0, 8'h00, "R1", "data after reset");
      rd(2'd2, 8'h40, "R1", "flags after reset");
      rd(2'd3, 8'h00, "R2", "unused offset");

      push_rsp(8'hA1, 1'b0); push_rsp(8'hA2, 1'b0); push_rsp(8'hA3, 1'b1);

      for (int i = 0; i < NV; i++) begin
         logic [15:0] e;
         string rq;
         e  = TBL[i];
         rq = $sformatf("R%0d", e[3:0]);
         case (e[15:14])
            KW: hw(e[13:12], e[11:4]);
            KR: rd(e[13:12], e[11:4], rq, $sformatf("table entry %0d", i));
            default: wait_idle();
         endcase
      end

      // R5 request FIFO contents and end marker
      chk(8'(ncap), 8'd3, "R5", "pushed byte count");
      chk(cap_b[0], 8'h11, "R5", "request byte 0");
      chk(cap_b[1], 8'h22, "R5", "request byte 1");
      chk(cap_b[2], 8'h33, "R5", "request byte 2");
      chk({7'd0, cap_e[0]} | {7'd0, cap_e[1]}, 8'h00, "R5", "early end marker");
      chk({7'd0, cap_e[2]}, 8'h01, "R5", "final end marker");

      // R10 get-status mid-write, then R11 out-of-order next
      hw(2'd0, 8'h70);
      step(8'h41, 8'hC1, "R5");
      step(8'h40, 8'hC0, "R10");
      step(8'h42, 8'hCF, "R11");
      chk(8'(ncap), 8'd4, "R11", "no push on out-of-order next");

      // R11 unknown operation and foreign stream
      step(8'h47, 8'hCF, "R11");
      step(8'h61, 8'hCF, "R11");

      // R11 push refused while request FIFO full
      req_full = 1'b1;
      step(8'h41, 8'hCF, "R11");
      chk(8'(ncap), 8'd4, "R11", "no push while full");
      rd(2'd2, 8'h00, "R2", "flags with full request and empty response");
      req_full = 1'b0;

      // R11 pop refused while response FIFO empty
      step(8'h41, 8'hC1, "R5");
      step(8'h43, 8'hC3, "R5");
      step(8'h44, 8'hCF, "R11");
      chk(8'(rwp - rrp), 8'd0, "R11", "no pop while empty");

      // R2 message-available in ready phase
      push_rsp(8'h5A, 1'b1);
      rd(2'd2, 8'hC4, "R2", "flags with waiting response");
      req_full = 1'b1;
      rd(2'd2, 8'h84, "R2", "flags with waiting response and full request");
      req_full = 1'b0;

      // R3 and R4: writes inside a long busy window
      proc_delay = 8'd8;
      hw(2'd1, 8'h40);
      hw(2'd0, 8'h55);
      hw(2'd2, 8'h01);
      hw(2'd2, 8'h00);
      hw(2'd0, 8'h99);
      hw(2'd1, 8'h4F);
      rd(2'd2, 8'hC5, "R3", "busy held after host writes zero");
      wait_idle();
      rd(2'd1, 8'hC0, "R4", "status from original code");
      rd(2'd0, 8'h55, "R4", "data not overwritten while busy");

      // R3 busy duration equals delay plus one
      proc_delay = 8'd3;
      begin
         int cnt;
         cnt = 0;
         hw(2'd2, 8'h01);
         hst_addr = 2'd2;
         #1;
         for (int k = 0; k < 50 && hst_rdata[0]; k++) begin
            cnt++;
            @(negedge clk);
            hst_addr = 2'd2;
            #1;
         end
         chk(8'(cnt), 8'd4, "R3", "busy cycles for delay 3");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule